// File: doc/BRIEF.md
# TDM Serial Audio Input Deserializer

This block receives time-division-multiplexed serial audio. It runs on the bit clock. On each rising edge it samples a frame strobe and one data lane, picked out of sixteen. A frame edge on the strobe starts a frame. After a programmable number of bit-clock cycles the block starts to collect bits into slots of a programmable width. For every completed slot it emits one 32-bit word with a single-cycle valid strobe and the slot number.

Two framing styles are supported. A two-phase word-select frame restarts the slot count on every level change of the strobe. A pulse frame restarts it only on the strobe's rising edge. The strobe can be inverted before framing. Received bits can be packed from bit 31 downward or from bit 0 upward. A per-slot enable mask drops slots entirely. A per-slot mute mask replaces a slot's data with a programmed value.

Configuration sits in a bank of 32-bit registers written from the same clock. The control word carries two separate active-low resets, one for the input side and one for the output side. Capture begins only after these are released in the required order and the run bit is set.

Top module: `tdm_rx_deser`

## Requirements
- R1: After reset the control word reads 0, the lane map word reads 0x76543210, the status word reads 0 and out_valid is low.
- R2: Word addresses are: control 0x00, lane map 0x04, enable mask word n at 0x08+4n, status 0x18 (read only), mute value 0x1C, mute mask word n at 0x20+4n (n = 0..3). Every writable word reads back the value last written.
- R3: Control bit 29 (output-side reset) and bit 28 (input-side reset) are active low. The block arms only when both are first low, then bit 29 is set while bit 28 stays low, then bit 28 is set. Any other order leaves it unarmed. Clearing either bit disarms it in the next cycle. Clearing bit 29 forces out_valid low. Words are produced only while armed with the run bit 31 set.
- R4: Control bits 23:20 name a lane. Lanes 8..15 are used directly. For a name below 8, the lane used is the nibble of the lane map word at bit position 4×name.
- R5: Control bits 18:16 give the skew s. The first bit of a frame is the lane sample taken s clock edges after the edge at which the frame edge was sampled (s = 0: that same edge).
- R6: With control bit 30 set (two-phase), both strobe transitions restart at slot 0. With it clear (pulse), only a low-to-high transition does.
- R7: Control bit 25 inverts the strobe before edge detection.
- R8: Control bits 4:0 hold the slot width minus one. A slot's word is on out_data and out_slot, with out_valid high for one cycle, in the cycle after the edge that samples the slot's last bit.
- R9: With control bit 5 clear, the k-th received bit of a slot lands at bit 31−k and all lower bits are 0.
- R10: With control bit 5 set, the k-th received bit lands at bit k and all higher bits are 0.
- R11: Slot n produces a word only if bit n mod 32 of enable mask word n div 32 is set.
- R12: A slot whose mute mask bit (same layout as the enable mask) is set outputs the mute value in place of its data.
- R13: The status word holds the armed state in bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address bits 5:2 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| ws_in | input | 1 | Frame / word-select strobe |
| lanes_in | input | N_LANES | Serial data lanes |
| out_valid | output | 1 | One-cycle strobe for a completed slot word |
| out_data | output | 32 | Captured (or muted) slot word |
| out_slot | output | SLOT_W | Slot number of out_data |

## Verification
The bench builds the block with its default sixteen lanes and four mask words. It sweeps both framing styles, both packing orders and every skew from 0 to 7. Each combination is run at slot widths of 1, 3, 8, 17 and 32, with strobe inversion and the lane choice varied alongside. Every expected word and its exact arrival cycle are derived arithmetically from the generated sample values. Because the unselected lanes carry the complement of the real data, a wrong lane or a bit placed one cycle off shows up at once. Directed runs cover a remapped lower lane, a wrong-order reset release, and mask and mute patterns that drop or replace individual slots.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;
  // control word bit positions
  localparam int B_RUN   = 31;
  localparam int B_TWOPH = 30;
  localparam int B_ORSTN = 29;
  localparam int B_IRSTN = 28;
  localparam int B_INV   = 25;
  localparam int F_LANE  = 20;
  localparam int F_SKEW  = 16;
  localparam int B_LSBF  = 5;

  // word indexes (byte address / 4)
  localparam logic [3:0] IX_CTRL  = 4'd0;
  localparam logic [3:0] IX_MAP   = 4'd1;
  localparam logic [3:0] IX_EMASK = 4'd2;
  localparam logic [3:0] IX_STAT  = 4'd6;
  localparam logic [3:0] IX_MVAL  = 4'd7;
  localparam logic [3:0] IX_MMASK = 4'd8;

  localparam logic [31:0] MAP_IDENT = 32'h7654_3210;

  typedef enum logic [1:0] {SQ_IDLE, SQ_BOTH, SQ_OUTREL, SQ_ARMED} seq_e;

  // lower eight lane names go through the map word, upper eight are direct
  function automatic logic [3:0] lane_of(input logic [31:0] map, input logic [3:0] name);
    if (name[3]) return name;
    return map[{name[2:0], 2'b00} +: 4];
  endfunction

  // bit position in the output word for the k-th received bit
  function automatic logic [4:0] place_of(input logic [4:0] k, input logic lsbf);
    return lsbf ? k : 5'd31 - k;
  endfunction
endpackage

// File: rtl/tdmrx_regs.sv
module tdmrx_regs
  import tdmrx_pkg::*;
#(
  parameter int MASK_WORDS = 4,
  localparam int MBITS = 32 * MASK_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [3:0]       idx,
  input  logic [31:0]      wdata,
  input  logic             armed,
  output logic [31:0]      ctrl,
  output logic [31:0]      lmap,
  output logic [MBITS-1:0] emask,
  output logic [MBITS-1:0] mmask,
  output logic [31:0]      mval,
  output logic [31:0]      rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      lmap  <= MAP_IDENT;
      emask <= '0;
      mmask <= '0;
      mval  <= '0;
    end else if (we) begin
      if (idx == IX_CTRL) ctrl <= wdata;
      if (idx == IX_MAP)  lmap <= wdata;
      if (idx == IX_MVAL) mval <= wdata;
      for (int k = 0; k < MASK_WORDS; k++) begin
        if (idx == IX_EMASK + 4'(k)) emask[32*k +: 32] <= wdata;
        if (idx == IX_MMASK + 4'(k)) mmask[32*k +: 32] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (idx == IX_CTRL) rdata = ctrl;
    if (idx == IX_MAP)  rdata = lmap;
    if (idx == IX_MVAL) rdata = mval;
    if (idx == IX_STAT) rdata = {31'd0, armed};
    for (int k = 0; k < MASK_WORDS; k++) begin
      if (idx == IX_EMASK + 4'(k)) rdata = emask[32*k +: 32];
      if (idx == IX_MMASK + 4'(k)) rdata = mmask[32*k +: 32];
    end
  end
endmodule

// File: rtl/tdmrx_seq.sv
module tdmrx_seq
  import tdmrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic orst_n,
  input  logic irst_n,
  output logic armed
);
  seq_e st, st_nx;

  always_comb begin
    st_nx = SQ_IDLE;
    if (!orst_n && !irst_n) st_nx = SQ_BOTH;
    else begin
      unique case (st)
        SQ_BOTH:   st_nx = (orst_n && !irst_n) ? SQ_OUTREL : SQ_IDLE;
        SQ_OUTREL: st_nx = !orst_n ? SQ_IDLE : (irst_n ? SQ_ARMED : SQ_OUTREL);
        SQ_ARMED:  st_nx = (orst_n && irst_n) ? SQ_ARMED : SQ_IDLE;
        default:   st_nx = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= st_nx;
  end

  assign armed = (st == SQ_ARMED);
endmodule

// File: rtl/tdmrx_framer.sv
module tdmrx_framer #(
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              ws_in,
  input  logic              inv,
  input  logic              twoph,
  input  logic [2:0]        skew,
  input  logic [4:0]        width_m1,
  output logic              take,
  output logic              first,
  output logic [4:0]        pos,
  output logic [SLOT_W-1:0] slot,
  output logic              last,
  output logic              fedge
);
  logic              ws_prev, waiting, running;
  logic [2:0]        wcnt;
  logic [4:0]        bcnt;
  logic [SLOT_W-1:0] scnt;
  logic              frm, edge_raw;

  assign frm      = ws_in ^ inv;
  assign edge_raw = twoph ? (frm ^ ws_prev) : (frm & ~ws_prev);
  assign fedge    = !clear && edge_raw;
  assign first    = !clear && ((edge_raw && skew == 3'd0) ||
                               (!edge_raw && waiting && wcnt == 3'd0));
  assign take     = first || (!clear && !edge_raw && running);
  assign pos      = first ? 5'd0 : bcnt;
  assign slot     = first ? '0 : scnt;
  assign last     = (pos == width_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev <= 1'b0;
      waiting <= 1'b0;
      running <= 1'b0;
      wcnt    <= '0;
      bcnt    <= '0;
      scnt    <= '0;
    end else begin
      ws_prev <= frm;
      if (clear) begin
        waiting <= 1'b0;
        running <= 1'b0;
        bcnt    <= '0;
        scnt    <= '0;
      end else begin
        if (edge_raw) begin
          running <= (skew == 3'd0);
          waiting <= (skew != 3'd0);
          wcnt    <= skew - 3'd1;
        end else if (waiting && wcnt != 3'd0) begin
          wcnt <= wcnt - 3'd1;
        end else if (waiting) begin
          waiting <= 1'b0;
          running <= 1'b1;
        end
        if (take) begin
          bcnt <= last ? 5'd0 : pos + 5'd1;
          scnt <= last ? slot + 1'b1 : slot;
        end
      end
    end
  end
endmodule

// File: rtl/tdmrx_packer.sv
module tdmrx_packer
  import tdmrx_pkg::*;
#(
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [4:0]        pos,
  input  logic [SLOT_W-1:0] slot,
  input  logic              last,
  input  logic              din,
  input  logic              lsbf,
  input  logic              chan_en,
  input  logic              mute_en,
  input  logic [31:0]       mval,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic [SLOT_W-1:0] out_slot
);
  logic [31:0] acc, word_nx;

  assign word_nx = ((pos == 5'd0) ? 32'd0 : acc) |
                   (32'(din) << place_of(pos, lsbf));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_slot  <= '0;
    end else if (clear) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_slot  <= '0;
    end else begin
      out_valid <= take && last && chan_en;
      if (take) acc <= word_nx;
      if (take && last && chan_en) begin
        out_data <= mute_en ? mval : word_nx;
        out_slot <= slot;
      end
    end
  end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdmrx_pkg::*;
#(
  parameter int N_LANES    = 16,
  parameter int MASK_WORDS = 4,
  localparam int LANE_W = $clog2(N_LANES),
  localparam int SLOT_W = $clog2(32 * MASK_WORDS),
  localparam int MBITS  = 32 * MASK_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [5:2]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               ws_in,
  input  logic [N_LANES-1:0] lanes_in,
  output logic               out_valid,
  output logic [31:0]        out_data,
  output logic [SLOT_W-1:0]  out_slot
);
  logic [31:0]       ctrl, lmap, mval;
  logic [MBITS-1:0]  emask, mmask;
  logic              armed, active, din;
  logic [3:0]        lane_phys;
  logic              fr_take, fr_first, fr_last, fr_edge;
  logic [4:0]        fr_pos;
  logic [SLOT_W-1:0] fr_slot;
  logic              chan_en, mute_en;

  tdmrx_regs #(.MASK_WORDS(MASK_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_addr), .wdata(reg_wdata),
    .armed(armed), .ctrl(ctrl), .lmap(lmap), .emask(emask), .mmask(mmask),
    .mval(mval), .rdata(reg_rdata)
  );

  tdmrx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .orst_n(ctrl[B_ORSTN]), .irst_n(ctrl[B_IRSTN]),
    .armed(armed)
  );

  assign active    = armed && ctrl[B_RUN];
  assign lane_phys = lane_of(lmap, ctrl[F_LANE +: 4]);
  assign din       = lanes_in[lane_phys[LANE_W-1:0]];

  tdmrx_framer #(.SLOT_W(SLOT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .clear(!active), .ws_in(ws_in),
    .inv(ctrl[B_INV]), .twoph(ctrl[B_TWOPH]), .skew(ctrl[F_SKEW +: 3]),
    .width_m1(ctrl[4:0]), .take(fr_take), .first(fr_first), .pos(fr_pos),
    .slot(fr_slot), .last(fr_last), .fedge(fr_edge)
  );

  assign chan_en = emask[fr_slot];
  assign mute_en = mmask[fr_slot];

  tdmrx_packer #(.SLOT_W(SLOT_W)) u_packer (
    .clk(clk), .rst_n(rst_n), .clear(!ctrl[B_ORSTN]), .take(fr_take),
    .pos(fr_pos), .slot(fr_slot), .last(fr_last), .din(din),
    .lsbf(ctrl[B_LSBF]), .chan_en(chan_en), .mute_en(mute_en), .mval(mval),
    .out_valid(out_valid), .out_data(out_data), .out_slot(out_slot)
  );
endmodule

// File: rtl/tdm_rx_deser_chk.sv
module tdm_rx_deser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl,
  input logic        armed,
  input logic        active,
  input logic        fr_take,
  input logic        fr_last,
  input logic        fr_edge,
  input logic        chan_en,
  input logic        mute_en,
  input logic [31:0] mval,
  input logic        out_valid,
  input logic [31:0] out_data
);
  p_out_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[29] |=> !out_valid);

  p_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[29] || !ctrl[28]) |=> !armed);

  p_valid_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(active));

  p_skew_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_edge && ctrl[18:16] >= 3'd2) |=> (!fr_take || fr_edge));

  p_slot_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(fr_take && fr_last));

  p_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_take && fr_last && !chan_en) |=> !out_valid);

  p_mute_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_take && fr_last && chan_en && mute_en && ctrl[29])
      |=> (out_valid && out_data == $past(mval)));
endmodule

bind tdm_rx_deser tdm_rx_deser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .armed(armed), .active(active),
  .fr_take(fr_take), .fr_last(fr_last), .fr_edge(fr_edge),
  .chan_en(chan_en), .mute_en(mute_en), .mval(mval),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tdm_rx_deser_bench.sv
`timescale 1ns/1ps
module tdm_rx_deser_bench;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:2]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ws = 1'b0;
  logic [15:0] lanes = '0;
  logic        ov;
  logic [31:0] od;
  logic [6:0]  os;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] q_data[$];
  int          q_slot[$];
  int          q_at[$];
  int          q_kind[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tdm_rx_deser u_tdm_rx_deser (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .ws_in(ws), .lanes_in(lanes), .out_valid(ov),
    .out_data(od), .out_slot(os)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a[5:2]; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a[5:2];
    #1 d = rdata;
  endtask

  function automatic logic [31:0] sval(input int g, input int n, input int w);
    logic [31:0] x;
    x = 32'h9E37_79B9 * 32'(g * 37 + n * 11 + w + 1);
    x = x ^ (x >> 13);
    if (w < 32) x = x & ((32'd1 << w) - 32'd1);
    return x;
  endfunction

  // output monitor: each word compared against the arithmetic expectation
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ov) begin
        n_chk++;
        if (q_data.size() == 0) begin
          n_bad++;
          $display("FAIL R11 R3: unexpected word slot %0d data %h, expected none", os, od);
        end else begin
          logic [31:0] ed;
          int es, ea, ek;
          string tg;
          ed = q_data.pop_front(); es = q_slot.pop_front();
          ea = q_at.pop_front();   ek = q_kind.pop_front();
          tg = (ek == 2) ? "R12" : ((ek == 1) ? "R10" : "R9");
          if (od !== ed || int'(os) != es || cyc != ea) begin
            n_bad++;
            $display("FAIL %s (R4 R5 R6 R7 R8): actual data %h slot %0d cycle %0d expected data %h slot %0d cycle %0d",
                     tg, od, os, cyc, ed, es, ea);
          end
        end
      end
    end
  end

  task automatic run(input bit twoph, input bit inv, input bit lsbf, input int skew,
                     input int w, input int sel, input int phys, input logic [31:0] em,
                     input logic [31:0] mm, input logic [31:0] mv, input bit expect_words);
    logic [31:0] cfg;
    int seg_len;
    cfg = (32'(twoph) << 30) | (32'd3 << 28) | (32'(inv) << 25) | (32'(sel) << 20) |
          (32'(skew) << 16) | (32'(lsbf) << 5) | 32'(w - 1);
    ws = inv; lanes = '0;
    wr(6'h00, cfg);
    wr(6'h08, em);
    wr(6'h20, mm);
    wr(6'h1C, mv);
    wr(6'h00, cfg | 32'h8000_0000);
    seg_len = NS * w + skew + 2;
    for (int g = 0; g < 2; g++) begin
      for (int c = 0; c < seg_len; c++) begin
        logic lvl, b;
        int k;
        @(negedge clk);
        if (c == 0 && expect_words) begin
          for (int n = 0; n < NS; n++) begin
            if (em[n]) begin
              logic [31:0] v;
              v = sval(g, n, w);
              q_data.push_back(mm[n] ? mv : (lsbf ? v : v << (32 - w)));
              q_slot.push_back(n);
              q_at.push_back(cyc + 1 + skew + (n + 1) * w - 1);
              q_kind.push_back(mm[n] ? 2 : (lsbf ? 1 : 0));
            end
          end
        end
        lvl = twoph ? (g == 0) : (c == 0);
        ws = lvl ^ inv;
        k = c - skew;
        b = 1'b0;
        if (k >= 0 && k < NS * w) begin
          logic [31:0] v;
          v = sval(g, k / w, w);
          b = lsbf ? v[k % w] : v[w - 1 - (k % w)];
        end
        lanes = {16{~b}};
        lanes[phys] = b;
      end
    end
    @(negedge clk);
    ws = inv;
    wr(6'h00, cfg);
    check(q_data.size() == 0, "R11 R8 words outstanding", 32'(q_data.size()), 32'd0);
    q_data.delete(); q_slot.delete(); q_at.delete(); q_kind.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int widths[5];
    widths = '{1, 3, 8, 17, 32};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(6'h00, d); check(d == 32'd0, "R1 control", d, 32'd0);
    rd(6'h04, d); check(d == 32'h7654_3210, "R1 lane map", d, 32'h7654_3210);
    rd(6'h18, d); check(d == 32'd0, "R1 R13 status", d, 32'd0);
    check(ov == 1'b0, "R1 out_valid", 32'(ov), 32'd0);

    // R2 register map read-back
    wr(6'h0C, 32'h1234_5678); rd(6'h0C, d); check(d == 32'h1234_5678, "R2 enable mask 1", d, 32'h1234_5678);
    wr(6'h14, 32'hCAFE_0001); rd(6'h14, d); check(d == 32'hCAFE_0001, "R2 enable mask 3", d, 32'hCAFE_0001);
    wr(6'h2C, 32'h0F0F_00FF); rd(6'h2C, d); check(d == 32'h0F0F_00FF, "R2 mute mask 3", d, 32'h0F0F_00FF);
    wr(6'h1C, 32'hDEAD_BEEF); rd(6'h1C, d); check(d == 32'hDEAD_BEEF, "R2 mute value", d, 32'hDEAD_BEEF);
    rd(6'h08, d); check(d == 32'd0, "R2 enable mask 0 untouched", d, 32'd0);
    wr(6'h0C, 32'd0); wr(6'h14, 32'd0); wr(6'h2C, 32'd0);

    // R3 wrong release order: input side first
    wr(6'h00, 32'h0000_0000);
    wr(6'h00, 32'h1000_0000);
    wr(6'h00, 32'h3000_0000);
    rd(6'h18, d); check(d == 32'd0, "R3 R13 unarmed after wrong order", d, 32'd0);
    run(1'b0, 1'b0, 1'b0, 1, 8, 9, 9, 32'hF, 32'h0, 32'h0, 1'b0);

    // R3 correct order
    wr(6'h00, 32'h0000_0000);
    wr(6'h00, 32'h2000_0000);
    wr(6'h00, 32'h3000_0000);
    rd(6'h18, d); check(d == 32'd1, "R3 R13 armed after correct order", d, 32'd1);

    // sweep: framing style, packing order, skew, width
    for (int tp = 0; tp < 2; tp++)
      for (int lf = 0; lf < 2; lf++)
        for (int sk = 0; sk < 8; sk++)
          for (int wi = 0; wi < 5; wi++) begin
            int sel;
            logic [31:0] em, mm;
            sel = (sk * 3 + wi + 8 * tp) % 16;
            em  = 32'hF & ~(32'd1 << ((sk + wi) % 5));
            mm  = (sk[1] ^ lf) ? (32'd1 << ((sk + wi + 1) % 4)) : 32'd0;
            run(tp[0], sk[0] ^ lf[0], lf[0], sk, widths[wi], sel, sel,
                em, mm, 32'hA5C3_0000 | 32'(sk * 16 + wi), 1'b1);
          end

    // R4 remapped lower lane: name 2 routed to lane 11
    wr(6'h04, 32'h7654_3B10);
    run(1'b1, 1'b0, 1'b0, 2, 8, 2, 11, 32'hF, 32'h0, 32'h0, 1'b1);
    run(1'b0, 1'b1, 1'b1, 0, 5, 2, 11, 32'h9, 32'h8, 32'h0000_0077, 1'b1);
    wr(6'h04, 32'h7654_3210);

    // R3 output-side reset drops armed state
    wr(6'h00, 32'h9000_0000);
    rd(6'h18, d); check(d == 32'd0, "R3 R13 disarmed by output reset", d, 32'd0);
    check(ov == 1'b0, "R3 out_valid held low", 32'(ov), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule